// File: doc/BRIEF.md
# Serial Flash Command Front End with SPI/QPI Mode Switch

This block sits on the target side of a serial flash device, between the host-facing pins and the storage back end. The host frames each transaction with an active-low chip select. It clocks in an instruction byte, an optional 24-bit address and optional write data. The block runs on a fast local clock and oversamples the serial clock. It takes input bits on serial-clock rising edges and changes output bits on falling edges. Because it detects edges in both directions, a host may idle the serial clock low (SPI mode 0) or high (SPI mode 3).

A mode bit that persists across transactions selects one of two lane widths. In single-line mode, bits arrive on lane 0 and read data leaves on lane 1. In quad mode, all four lanes carry nibbles, high nibble first, in both directions, so an instruction byte takes two serial clocks. The back end receives a decoded instruction strobe, the assembled address with a strobe, a strobe for each write byte, and a pulse asking for the next read byte.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, all output enables are low, quad mode is off and no strobe is active.
- R2: In single-line mode, eight lane-0 bits sampled on serial-clock rising edges, MSB first, form the instruction. It is reported with a one-cycle `cmd_valid` pulse on `cmd_code`.
- R3: Instruction 02h (write) and instruction 03h (read) are each followed by a 24-bit address, MSB first. It is reported with a one-cycle `addr_valid` pulse. No other instruction takes an address.
- R4: Transactions clocked with the serial clock idling high decode exactly like those with it idling low.
- R5: After the address of instruction 02h, every further 8 bits (or 2 nibbles in quad mode) produce a `data_valid` pulse with the byte on `data_byte`.
- R6: After the address of instruction 03h, read data is driven on serial-clock falling edges, MSB first, starting at the falling edge after the last address bit. `rd_load` pulses as each new `rd_byte` is taken.
- R7: Output enables are high only in the read-data phase: lane 1 alone in single-line mode, all four lanes in quad mode.
- R8: All output enables go low as soon as chip select goes high.
- R9: Chip select going high discards any partial instruction, address or byte. The next transaction decodes from its first bit, and the quad-mode bit keeps its value.
- R10: Instruction 35h turns quad mode on. It takes effect as soon as the instruction completes.
- R11: In quad mode, each serial-clock rising edge samples a nibble with lane 3 as its MSB. An instruction takes 2 clocks, an address 6 clocks and a data byte 2 clocks.
- R12: In quad mode, read data leaves on all four lanes, high nibble first, one nibble per falling edge.
- R13: Instruction F5h turns quad mode off.
- R14: Instruction 99h (software reset) and the hardware reset input both return the device to single-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select from host |
| io_i | input | 4 | Input value of the four data lanes |
| io_o | output | 4 | Output value of the four data lanes |
| io_oe | output | 4 | Per-lane output enable |
| qpi_mode | output | 1 | Quad mode active |
| cmd_valid | output | 1 | Instruction-complete strobe |
| cmd_code | output | 8 | Last decoded instruction |
| addr_valid | output | 1 | Address-complete strobe |
| addr | output | 24 | Last assembled address |
| data_valid | output | 1 | Write-byte strobe |
| data_byte | output | 8 | Last received write byte |
| rd_byte | input | 8 | Next read byte from back end |
| rd_load | output | 1 | Pulse: `rd_byte` was taken |

## Verification
A lane-width bit holding the wrong value misframes the very next instruction. The back end then receives a wrong `cmd_code`, or no strobe at all, a few local clocks after the second or eighth serial-clock rise. A bit counter left stale by an abort shifts every later field, so the first strobe of the next transaction already carries a rotated value. A wrong output shifter or phase state shows at the lanes on the first sampled read bit, and shows on `io_oe` before any data is checked.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DIN,
    PH_DOUT,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_PROG     = 8'h02;
  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_QUAD_ON  = 8'h35;
  localparam logic [7:0] OP_QUAD_OFF = 8'hF5;
  localparam logic [7:0] OP_SOFT_RST = 8'h99;
endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/flash_fe_rx.sv
module flash_fe_rx
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_act,
  input  logic [3:0]        din,
  output logic              qpi,
  output logic              rd_phase,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              din_valid,
  output logic [7:0]        din_byte
);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BYTE_S = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_BYTE_Q = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_ADDR_S = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR_Q = CNT_W'(ADDR_W / 4 - 1);

  phase_t              phase_q, phase_nx;
  logic [CNT_W-1:0]    cnt_q, cnt_nx;
  logic [ADDR_W-1:0]   sh_q, sh_nx, sh_in;
  logic [ADDR_W-1:0]   addr_q, addr_nx;
  logic [7:0]          cmd_q, cmd_nx, byte_q, byte_nx;
  logic                qpi_q, qpi_nx;
  logic                cmd_v_q, cmd_v_nx, addr_v_q, addr_v_nx, din_v_q, din_v_nx;
  logic [CNT_W-1:0]    last_byte, last_addr;

  always_comb begin
    sh_in     = qpi_q ? {sh_q[ADDR_W-5:0], din} : {sh_q[ADDR_W-2:0], din[0]};
    last_byte = qpi_q ? LAST_BYTE_Q : LAST_BYTE_S;
    last_addr = qpi_q ? LAST_ADDR_Q : LAST_ADDR_S;
    phase_nx  = phase_q;
    cnt_nx    = cnt_q;
    sh_nx     = sh_q;
    addr_nx   = addr_q;
    cmd_nx    = cmd_q;
    byte_nx   = byte_q;
    qpi_nx    = qpi_q;
    cmd_v_nx  = 1'b0;
    addr_v_nx = 1'b0;
    din_v_nx  = 1'b0;
    if (!cs_act) begin
      phase_nx = PH_CMD;
      cnt_nx   = '0;
    end else if (sck_rise) begin
      sh_nx  = sh_in;
      cnt_nx = cnt_q + CNT_W'(1);
      unique case (phase_q)
        PH_CMD: if (cnt_q == last_byte) begin
          cnt_nx   = '0;
          cmd_v_nx = 1'b1;
          cmd_nx   = sh_in[7:0];
          phase_nx = PH_SKIP;
          case (sh_in[7:0])
            OP_READ, OP_PROG:         phase_nx = PH_ADDR;
            OP_QUAD_ON:               qpi_nx   = 1'b1;
            OP_QUAD_OFF, OP_SOFT_RST: qpi_nx   = 1'b0;
            default:                  ;
          endcase
        end
        PH_ADDR: if (cnt_q == last_addr) begin
          cnt_nx    = '0;
          addr_v_nx = 1'b1;
          addr_nx   = sh_in;
          phase_nx  = (cmd_q == OP_READ) ? PH_DOUT : PH_DIN;
        end
        PH_DIN: if (cnt_q == last_byte) begin
          cnt_nx   = '0;
          din_v_nx = 1'b1;
          byte_nx  = sh_in[7:0];
        end
        default: cnt_nx = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      cnt_q    <= '0;
      sh_q     <= '0;
      addr_q   <= '0;
      cmd_q    <= '0;
      byte_q   <= '0;
      qpi_q    <= 1'b0;
      cmd_v_q  <= 1'b0;
      addr_v_q <= 1'b0;
      din_v_q  <= 1'b0;
    end else begin
      phase_q  <= phase_nx;
      cnt_q    <= cnt_nx;
      sh_q     <= sh_nx;
      addr_q   <= addr_nx;
      cmd_q    <= cmd_nx;
      byte_q   <= byte_nx;
      qpi_q    <= qpi_nx;
      cmd_v_q  <= cmd_v_nx;
      addr_v_q <= addr_v_nx;
      din_v_q  <= din_v_nx;
    end
  end

  assign qpi        = qpi_q;
  assign rd_phase   = (phase_q == PH_DOUT);
  assign cmd_valid  = cmd_v_q;
  assign cmd_code   = cmd_q;
  assign addr_valid = addr_v_q;
  assign addr       = addr_q;
  assign din_valid  = din_v_q;
  assign din_byte   = byte_q;

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_v_q, addr_v_q, din_v_q}));
  assert_quad_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v_q && cmd_q == OP_QUAD_ON) |-> qpi_q);
  assert_quad_leave_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v_q && cmd_q == OP_QUAD_OFF) |-> !qpi_q);
  assert_soft_reset_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v_q && cmd_q == OP_SOFT_RST) |-> !qpi_q);
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase_q == PH_CMD && cnt_q == '0));
  assert_abort_keeps_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable(qpi_q));
endmodule

// File: rtl/flash_fe_tx.sv
module flash_fe_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_fall,
  input  logic       cs_act,
  input  logic       rd_phase,
  input  logic       qpi,
  input  logic [7:0] rd_byte,
  output logic [3:0] io_o,
  output logic       oe,
  output logic       rd_load
);
  logic [2:0] left_q, left_nx;
  logic [7:0] osh_q, osh_nx, word;
  logic [3:0] io_q, io_nx;
  logic       oe_q, oe_nx, load_q, load_nx;

  always_comb begin
    word    = (left_q == 3'd0) ? rd_byte : osh_q;
    left_nx = left_q;
    osh_nx  = osh_q;
    io_nx   = io_q;
    oe_nx   = oe_q;
    load_nx = 1'b0;
    if (!cs_act) begin
      left_nx = 3'd0;
      io_nx   = 4'd0;
      oe_nx   = 1'b0;
    end else if (sck_fall && rd_phase) begin
      oe_nx   = 1'b1;
      load_nx = (left_q == 3'd0);
      if (qpi) begin
        io_nx  = word[7:4];
        osh_nx = {word[3:0], 4'd0};
      end else begin
        io_nx  = {2'b00, word[7], 1'b0};
        osh_nx = {word[6:0], 1'b0};
      end
      if (left_q == 3'd0) left_nx = qpi ? 3'd1 : 3'd7;
      else                left_nx = left_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= 3'd0;
      osh_q  <= 8'd0;
      io_q   <= 4'd0;
      oe_q   <= 1'b0;
      load_q <= 1'b0;
    end else begin
      left_q <= left_nx;
      osh_q  <= osh_nx;
      io_q   <= io_nx;
      oe_q   <= oe_nx;
      load_q <= load_nx;
    end
  end

  assign io_o    = io_q;
  assign oe      = oe_q;
  assign rd_load = load_q;

  assert_drive_only_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> rd_phase);
  assert_release_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !oe_q);
  assert_load_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> (rd_phase && oe_q));
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic [3:0]        io_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe,
  output logic              qpi_mode,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              data_valid,
  output logic [7:0]        data_byte,
  input  logic [7:0]        rd_byte,
  output logic              rd_load
);
  localparam int PIN_W = 6;

  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic [PIN_W-1:0] pins_s;
  logic             sck_s, cs_s_n, sck_d;
  logic [3:0]       io_s;
  logic             sck_rise, sck_fall, cs_act;
  logic             rd_phase, qpi, oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  flash_fe_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(6'b100000)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_s_n),
    .d    ({cs_n, sck, io_i}),
    .q    (pins_s)
  );
  assign cs_s_n = pins_s[5];
  assign sck_s  = pins_s[4];
  assign io_s   = pins_s[3:0];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) sck_d <= 1'b0;
    else          sck_d <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_act   = ~cs_s_n;

  flash_fe_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sck_rise  (sck_rise),
    .cs_act    (cs_act),
    .din       (io_s),
    .qpi       (qpi),
    .rd_phase  (rd_phase),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .addr_valid(addr_valid),
    .addr      (addr),
    .din_valid (data_valid),
    .din_byte  (data_byte)
  );

  flash_fe_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .sck_fall(sck_fall),
    .cs_act  (cs_act),
    .rd_phase(rd_phase),
    .qpi     (qpi),
    .rd_byte (rd_byte),
    .io_o    (io_o),
    .oe      (oe),
    .rd_load (rd_load)
  );

  for (genvar l = 0; l < 4; l++) begin : g_lane_oe
    if (l == 1) begin : g_single
      assign io_oe[l] = oe & ~cs_n;
    end else begin : g_quad
      assign io_oe[l] = oe & qpi & ~cs_n;
    end
  end

  assign qpi_mode = qpi;
endmodule

// File: tb/flash_cmd_frontend_test.sv
module flash_cmd_frontend_test;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n, sck, cs_n;
  logic [3:0]  io_i, io_o, io_oe;
  logic        qpi_mode, cmd_valid, addr_valid, data_valid, rd_load;
  logic [7:0]  cmd_code, data_byte, rd_byte;
  logic [23:0] addr;

  int total = 0;
  int bad   = 0;

  typedef struct { int kind; logic [31:0] val; string req; } ev_t;
  ev_t sb[$];

  always #4 clk = ~clk;

  flash_cmd_frontend uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_i(io_i),
    .io_o(io_o), .io_oe(io_oe), .qpi_mode(qpi_mode),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_valid(addr_valid), .addr(addr),
    .data_valid(data_valid), .data_byte(data_byte),
    .rd_byte(rd_byte), .rd_load(rd_load)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input logic [31:0] v, input string r);
    ev_t e;
    e.kind = k; e.val = v; e.req = r;
    sb.push_back(e);
  endtask

  task automatic pop_cmp(input int k, input logic [31:0] v);
    ev_t e;
    if (sb.size() == 0) begin
      check(1'b0, "R2 unexpected strobe", v, 32'hFFFFFFFF);
    end else begin
      e = sb.pop_front();
      check(e.kind == k && e.val == v, e.req, v, e.val);
    end
  endtask

  // monitor: strobes from the design are compared against the queue
  always @(negedge clk) begin
    if (cmd_valid)  pop_cmp(0, {24'd0, cmd_code});
    if (addr_valid) pop_cmp(1, {8'd0, addr});
    if (data_valid) pop_cmp(2, {24'd0, data_byte});
  end

  // back end model: next read byte advances by 11h per load
  always @(posedge clk) if (rd_load) rd_byte <= rd_byte + 8'h11;

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_start(input bit m3);
    sck = m3;
    wait_h(H);
    cs_n = 1'b0;
    wait_h(H);
  endtask

  task automatic frame_end(input bit m3);
    sck = m3;
    wait_h(H);
    cs_n = 1'b1;
    #1;
    check(io_oe == 4'd0, "R8 oe released", io_oe, 0);
    wait_h(3 * H);
  endtask

  task automatic send(input logic [31:0] val, input int nbits, input bit q);
    int units;
    units = q ? nbits / 4 : nbits;
    for (int i = 0; i < units; i++) begin
      sck = 1'b0;
      if (q) io_i = val[nbits-1-4*i -: 4];
      else   io_i = {3'b000, val[nbits-1-i]};
      wait_h(H);
      sck = 1'b1;
      wait_h(H);
    end
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit q, input string req);
    logic [7:0] got;
    int units;
    got = 8'd0;
    units = q ? 2 : 8;
    for (int i = 0; i < units; i++) begin
      sck = 1'b0;
      wait_h(H);
      if (i == 0) check(io_oe == (q ? 4'hF : 4'h2), "R7 read lanes enabled", io_oe, q ? 4'hF : 4'h2);
      if (q) got = {got[3:0], io_o};
      else   got = {got[6:0], io_o[1]};
      sck = 1'b1;
      wait_h(H);
    end
    check(got == exp, req, got, exp);
  endtask

  task automatic sb_empty(input string req);
    check(sb.size() == 0, req, sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; io_i = 4'd0; rd_byte = 8'd0;
    wait_h(5);
    rst_n = 1'b1;
    wait_h(6);
    // R1 reset state
    check(io_oe == 4'd0, "R1 oe", io_oe, 0);
    check(qpi_mode == 1'b0, "R1 qpi", qpi_mode, 0);
    check({cmd_valid, addr_valid, data_valid, rd_load} == 4'd0, "R1 strobes",
          {cmd_valid, addr_valid, data_valid, rd_load}, 0);

    // R2 R3 R5: single-line write, clock idle low
    expect_ev(0, 32'h02, "R2 cmd");
    expect_ev(1, 32'h123456, "R3 addr");
    expect_ev(2, 32'hA5, "R5 data0");
    expect_ev(2, 32'h3C, "R5 data1");
    frame_start(0);
    send(32'h02, 8, 0);
    send(32'h123456, 24, 0);
    send(32'hA5, 8, 0);
    send(32'h3C, 8, 0);
    check(io_oe == 4'd0, "R7 no drive in write", io_oe, 0);
    frame_end(0);
    sb_empty("R5 all strobes seen");

    // R4: clock idle high
    expect_ev(0, 32'h02, "R4 cmd");
    expect_ev(1, 32'hABCDEF, "R4 addr");
    expect_ev(2, 32'h5A, "R4 data");
    frame_start(1);
    send(32'h02, 8, 0);
    send(32'hABCDEF, 24, 0);
    send(32'h5A, 8, 0);
    frame_end(1);
    sb_empty("R4 all strobes seen");

    // R6: single-line read
    rd_byte = 8'h96;
    expect_ev(0, 32'h03, "R6 cmd");
    expect_ev(1, 32'h00F0F0, "R3 read addr");
    frame_start(0);
    send(32'h03, 8, 0);
    check(io_oe == 4'd0, "R7 no drive before data", io_oe, 0);
    send(32'h00F0F0, 24, 0);
    recv_byte(8'h96, 0, "R6 byte0");
    recv_byte(8'hA7, 0, "R6 byte1");
    frame_end(0);
    sb_empty("R6 strobes");

    // R9: aborts mid-instruction and mid-address
    frame_start(0);
    send(32'hA, 4, 0);
    frame_end(0);
    expect_ev(0, 32'h02, "R9 cmd after abort");
    frame_start(0);
    send(32'h02, 8, 0);
    send(32'h77, 8, 0);
    frame_end(0);
    expect_ev(0, 32'h02, "R9 clean cmd");
    expect_ev(1, 32'h000102, "R9 clean addr");
    expect_ev(2, 32'h11, "R9 clean data");
    frame_start(0);
    send(32'h02, 8, 0);
    send(32'h000102, 24, 0);
    send(32'h11, 8, 0);
    frame_end(0);
    sb_empty("R9 strobes");

    // R10: enter quad mode
    expect_ev(0, 32'h35, "R10 cmd");
    frame_start(0);
    send(32'h35, 8, 0);
    frame_end(0);
    check(qpi_mode == 1'b1, "R10 quad on", qpi_mode, 1);

    // R11: quad write
    expect_ev(0, 32'h02, "R11 cmd");
    expect_ev(1, 32'h89ABCD, "R11 addr");
    expect_ev(2, 32'hE7, "R11 data");
    frame_start(0);
    send(32'h02, 8, 1);
    send(32'h89ABCD, 24, 1);
    send(32'hE7, 8, 1);
    frame_end(0);
    sb_empty("R11 strobes");

    // R12: quad read, clock idle high
    rd_byte = 8'h5C;
    expect_ev(0, 32'h03, "R12 cmd");
    expect_ev(1, 32'h000010, "R12 addr");
    frame_start(1);
    send(32'h03, 8, 1);
    send(32'h000010, 24, 1);
    recv_byte(8'h5C, 1, "R12 byte0");
    recv_byte(8'h6D, 1, "R12 byte1");
    frame_end(1);
    sb_empty("R12 strobes");

    // R9: abort in quad mode keeps mode
    frame_start(0);
    send(32'h3, 4, 1);
    frame_end(0);
    check(qpi_mode == 1'b1, "R9 mode kept", qpi_mode, 1);
    sb_empty("R9 no strobe on partial");

    // R13: leave quad mode, then single-line decode
    expect_ev(0, 32'hF5, "R13 cmd");
    frame_start(0);
    send(32'hF5, 8, 1);
    frame_end(0);
    check(qpi_mode == 1'b0, "R13 quad off", qpi_mode, 0);
    expect_ev(0, 32'h06, "R13 single-line after exit");
    frame_start(0);
    send(32'h06, 8, 0);
    frame_end(0);
    sb_empty("R13 strobes");

    // R14: software reset opcode
    expect_ev(0, 32'h35, "R14 enter");
    expect_ev(0, 32'h99, "R14 soft reset cmd");
    frame_start(0);
    send(32'h35, 8, 0);
    frame_end(0);
    frame_start(0);
    send(32'h99, 8, 1);
    frame_end(0);
    check(qpi_mode == 1'b0, "R14 soft reset", qpi_mode, 0);

    // R14: hardware reset
    expect_ev(0, 32'h35, "R14 enter again");
    frame_start(0);
    send(32'h35, 8, 0);
    frame_end(0);
    check(qpi_mode == 1'b1, "R14 quad before reset", qpi_mode, 1);
    rst_n = 1'b0;
    wait_h(3);
    check(qpi_mode == 1'b0, "R14 hw reset", qpi_mode, 0);
    rst_n = 1'b1;
    wait_h(6);
    expect_ev(0, 32'h06, "R14 single-line after reset");
    frame_start(0);
    send(32'h06, 8, 0);
    frame_end(0);
    sb_empty("R14 strobes");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule